// File: doc/BRIEF.md
# Hash Message Padder (MD5 / SHA-1 tail finisher)

This block closes out a message for a compression core that works on 32-bit words. A client hands it, in one request, whatever message bytes are still left over: a number of whole words, then a tail word with zero to three valid bytes. With them come the number of bytes already absorbed by the core and a mode select. The padder then plays out a word stream. The stream holds the leftover words, the tail word with the 0x80 marker merged in, as many zero words as are needed, and the 64-bit message length in bits. As a result the finished message ends on a 64-byte boundary.

The stream uses a ready/valid handshake. Bytes are packed little-endian into words, so the earliest byte of a word sits in bits 7:0. The two modes differ in two ways: how the fill count is derived, and the byte order of the length field. A one-cycle done pulse marks the end of a message, and the block is then free for the next request.

Top module: `hash_msg_padder`

## Requirements
- R1: During and right after reset, `out_valid_o` and `done_o` are low and `req_ready_o` is high.
- R2: A request is taken in a cycle where `req_valid_i` and `req_ready_o` are both high. The stream then starts with `req_words_i` whole words, in order. Word k is taken from `req_data_i[32k+31:32k]`.
- R3: The next word is the marker word, and it is always sent, even when the tail holds no bytes. Let n be `req_tail_bytes_i` and let the tail word be `req_data_i` word number `req_words_i`. The marker word keeps the tail's byte lanes below n, where lane j occupies bits 8j+7:8j. It puts 0x80 in lane n and zero in every lane above it. With n = 0 the word is 0x00000080.
- R4: With `req_mode_i` = 0 (MD5), idx = (`req_count_i` + 4·words + 4) mod 64. The marker word is followed by (56 − idx)/4 zero words when idx ≤ 56, otherwise by (120 − idx)/4 zero words.
- R5: With `req_mode_i` = 1 (SHA-1), idx = (`req_count_i` + 4·words + tail bytes) mod 64, and pad = 56 − idx when idx < 56, otherwise 120 − idx. The marker word is followed by (pad − 1)/4 zero words.
- R6: In MD5 mode the last two words carry B = 8 × total message bytes: bits 31:0 of B first, then bits 63:32.
- R7: In SHA-1 mode the last two words carry B in big-endian byte order. The first word has B[63:56] in lane 0 up to B[39:32] in lane 3. The second word has B[31:24] in lane 0 up to B[7:0] in lane 3.
- R8: When `req_count_i` is a multiple of 64, the number of words in one stream is a multiple of 16.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output word and `out_last_o` hold. `out_last_o` is high only on the second length word.
- R10: `done_o` is high for exactly one cycle, the cycle after the last length word is taken.
- R11: From the time a request is taken until the stream ends, `req_ready_o` is low, and a request offered during that time has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Padder idle, request can be taken |
| req_mode_i | input | 1 | 0 = MD5, 1 = SHA-1 |
| req_count_i | input | 64 | Bytes already absorbed before the leftover |
| req_words_i | input | 4 | Whole leftover words (0..15) |
| req_tail_bytes_i | input | 2 | Valid bytes in the tail word (0..3) |
| req_data_i | input | 512 | Leftover words, word k at bits 32k+31:32k |
| out_valid_o | output | 1 | Stream word valid |
| out_ready_i | input | 1 | Consumer takes the word |
| out_data_o | output | 32 | Stream word |
| out_last_o | output | 1 | Final length word |
| done_o | output | 1 | One-cycle end-of-message pulse |

## Verification
The hardest cases to reach are the points where the fill count wraps. In MD5 mode, idx = 56 must give no zero words and idx = 60 must give fifteen. In SHA-1 mode, idx = 55 must give no zero words and idx = 56 must give fifteen. These are reached by choosing the leftover word and tail counts directly (13 words with 2 or 3 tail bytes, 14 words with none, 15 words with 3). Byte counts with set bits above bit 32 are chosen so that both length words are non-zero and their order is visible. Separate runs drop `out_ready_i` every third cycle and offer a conflicting request in the middle of a stream.

// File: rtl/hpad_pkg.sv
`timescale 1ns/1ps
package hpad_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = 4;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned LEN_W   = 64;
  localparam logic [7:0]  MARK_B  = 8'h80;

  typedef enum logic {
    MODE_MD5  = 1'b0,
    MODE_SHA1 = 1'b1
  } hash_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DATA,
    PH_MARK,
    PH_ZERO,
    PH_LEN_LO,
    PH_LEN_HI
  } phase_e;

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/hpad_plan.sv
`timescale 1ns/1ps
// Zero-fill count and length words from captured request fields.
module hpad_plan
  import hpad_pkg::*;
#(
  parameter int unsigned BLOCK_WORDS = 16,
  localparam int unsigned WIDX_W     = $clog2(BLOCK_WORDS)
) (
  input  hash_mode_e        mode_i,
  input  logic [LEN_W-1:0]  count_i,
  input  logic [WIDX_W-1:0] nwords_i,
  input  logic [LANE_W-1:0] tail_n_i,
  output logic [WIDX_W-1:0] zeros_o,
  output logic [WORD_W-1:0] len_lo_o,
  output logic [WORD_W-1:0] len_hi_o
);
  localparam int unsigned BLOCK_BYTES = BLOCK_WORDS * 4;
  localparam int unsigned IDX_W       = $clog2(BLOCK_BYTES);
  localparam int unsigned LEN_POS     = BLOCK_BYTES - 8;

  logic [LEN_W-1:0] sent, total, bits;
  logic [IDX_W-1:0] md5_idx, sha_idx, md5_gap, sha_gap, gap;
  logic             unused_ok;

  assign sent  = count_i + LEN_W'({nwords_i, 2'b00});
  assign total = sent + LEN_W'(tail_n_i);
  assign bits  = {total[LEN_W-4:0], 3'b000};

  // MD5 index counts the marker word as four bytes; SHA-1 index counts real bytes
  assign md5_idx = sent[IDX_W-1:0] + IDX_W'(4);
  assign sha_idx = total[IDX_W-1:0];

  // Both branches of each formula collapse into one modulo-block subtraction
  assign md5_gap = IDX_W'(LEN_POS) - md5_idx;
  assign sha_gap = IDX_W'(LEN_POS - 1) - sha_idx;
  assign gap     = (mode_i == MODE_SHA1) ? sha_gap : md5_gap;
  assign zeros_o = gap[IDX_W-1:2];

  always_comb begin
    if (mode_i == MODE_SHA1) begin
      len_lo_o = bswap32(bits[63:32]);
      len_hi_o = bswap32(bits[31:0]);
    end else begin
      len_lo_o = bits[31:0];
      len_hi_o = bits[63:32];
    end
  end

  assign unused_ok = ^{gap[1:0], total[LEN_W-1:LEN_W-3]};
endmodule

// File: rtl/hpad_tail.sv
`timescale 1ns/1ps
// Masks the partial tail word and drops the marker byte above it.
module hpad_tail
  import hpad_pkg::*;
(
  input  logic [WORD_W-1:0] tail_i,
  input  logic [LANE_W-1:0] tail_n_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign word_o[8*b +: 8] = (LANE_W'(b) < tail_n_i)  ? tail_i[8*b +: 8] :
                              (LANE_W'(b) == tail_n_i) ? MARK_B : 8'h00;
  end
endmodule

// File: rtl/hpad_seq.sv
`timescale 1ns/1ps
// Phase sequencer for data, marker, zero fill and length words.
module hpad_seq
  import hpad_pkg::*;
#(
  parameter int unsigned BLOCK_WORDS = 16,
  localparam int unsigned WIDX_W     = $clog2(BLOCK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIDX_W-1:0] nwords_i,
  input  logic [WIDX_W-1:0] nwords_q_i,
  input  logic [WIDX_W-1:0] zeros_i,
  input  logic              out_ready_i,
  output phase_e            phase_o,
  output logic [WIDX_W-1:0] cnt_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              idle_o,
  output logic              done_o
);
  phase_e            phase_q;
  logic [WIDX_W-1:0] cnt_q, cnt_inc;
  logic              done_q, fire;

  assign fire    = out_valid_o && out_ready_i;
  assign cnt_inc = cnt_q + WIDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= (nwords_i != '0) ? PH_DATA : PH_MARK;
          cnt_q   <= '0;
        end
        PH_DATA: if (fire) begin
          if (cnt_inc == nwords_q_i) begin
            phase_q <= PH_MARK;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_MARK: if (fire) begin
          phase_q <= (zeros_i != '0) ? PH_ZERO : PH_LEN_LO;
          cnt_q   <= '0;
        end
        PH_ZERO: if (fire) begin
          if (cnt_inc == zeros_i) begin
            phase_q <= PH_LEN_LO;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_LEN_LO: if (fire) phase_q <= PH_LEN_HI;
        PH_LEN_HI: if (fire) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign cnt_o       = cnt_q;
  assign out_valid_o = (phase_q != PH_IDLE);
  assign out_last_o  = (phase_q == PH_LEN_HI);
  assign idle_o      = (phase_q == PH_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/hash_msg_padder.sv
`timescale 1ns/1ps
module hash_msg_padder
  import hpad_pkg::*;
#(
  parameter int unsigned BLOCK_WORDS = 16,
  localparam int unsigned WIDX_W     = $clog2(BLOCK_WORDS),
  localparam int unsigned DATA_W     = BLOCK_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_mode_i,
  input  logic [LEN_W-1:0]  req_count_i,
  input  logic [WIDX_W-1:0] req_words_i,
  input  logic [LANE_W-1:0] req_tail_bytes_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              done_o
);
  hash_mode_e        mode_q;
  logic [LEN_W-1:0]  count_q;
  logic [WIDX_W-1:0] nwords_q, zeros, cnt;
  logic [LANE_W-1:0] tail_n_q;
  logic [WORD_W-1:0] data_q [BLOCK_WORDS];
  logic [WORD_W-1:0] mark_word, len_lo, len_hi;
  logic              accept;
  phase_e            phase;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_MD5;
      count_q  <= '0;
      nwords_q <= '0;
      tail_n_q <= '0;
    end else if (accept) begin
      mode_q   <= hash_mode_e'(req_mode_i);
      count_q  <= req_count_i;
      nwords_q <= req_words_i;
      tail_n_q <= req_tail_bytes_i;
    end
  end

  // Datapath holding registers, no reset needed
  for (genvar k = 0; k < BLOCK_WORDS; k++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (accept) data_q[k] <= req_data_i[WORD_W*k +: WORD_W];
    end
  end

  hpad_plan #(.BLOCK_WORDS(BLOCK_WORDS)) u_plan (
    .mode_i   (mode_q),
    .count_i  (count_q),
    .nwords_i (nwords_q),
    .tail_n_i (tail_n_q),
    .zeros_o  (zeros),
    .len_lo_o (len_lo),
    .len_hi_o (len_hi)
  );

  hpad_tail u_tail (
    .tail_i   (data_q[nwords_q]),
    .tail_n_i (tail_n_q),
    .word_o   (mark_word)
  );

  hpad_seq #(.BLOCK_WORDS(BLOCK_WORDS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .nwords_i    (req_words_i),
    .nwords_q_i  (nwords_q),
    .zeros_i     (zeros),
    .out_ready_i (out_ready_i),
    .phase_o     (phase),
    .cnt_o       (cnt),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .idle_o      (req_ready_o),
    .done_o      (done_o)
  );

  always_comb begin
    unique case (phase)
      PH_DATA:   out_data_o = data_q[cnt];
      PH_MARK:   out_data_o = mark_word;
      PH_LEN_LO: out_data_o = len_lo;
      PH_LEN_HI: out_data_o = len_hi;
      default:   out_data_o = '0;
    endcase
  end
endmodule

// File: rtl/hpad_chk.sv
`timescale 1ns/1ps
module hpad_chk #(
  parameter int unsigned BLOCK_WORDS = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic        out_last_o,
  input logic        done_o
);
  logic [7:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       beat_q <= '0;
    else if (req_valid_i && req_ready_o) beat_q <= '0;
    else if (out_valid_o && out_ready_i) beat_q <= beat_q + 8'd1;
  end

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R9
  last_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  // R10
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !out_valid_o);

  // R8
  block_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |->
      ((beat_q % 8'(BLOCK_WORDS)) == 8'(BLOCK_WORDS - 1)));
endmodule

bind hash_msg_padder hpad_chk #(.BLOCK_WORDS(BLOCK_WORDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .done_o      (done_o)
);

// File: tb/hash_msg_padder_tb.sv
`timescale 1ns/1ps
module hash_msg_padder_tb;
  localparam int BW = 16;
  localparam int DW = BW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_mode = 1'b0;
  logic [63:0]   req_count = '0;
  logic [3:0]    req_words = '0;
  logic [1:0]    req_tail = '0;
  logic [DW-1:0] req_data = '0;
  logic          out_valid, out_last, done;
  logic          out_ready = 1'b0;
  logic [31:0]   out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] exp_w   [64];
  string       exp_tag [64];
  int          exp_n;

  always #2.5 clk = ~clk;

  hash_msg_padder u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .req_valid_i      (req_valid),
    .req_ready_o      (req_ready),
    .req_mode_i       (req_mode),
    .req_count_i      (req_count),
    .req_words_i      (req_words),
    .req_tail_bytes_i (req_tail),
    .req_data_i       (req_data),
    .out_valid_o      (out_valid),
    .out_ready_i      (out_ready),
    .out_data_o       (out_data),
    .out_last_o       (out_last),
    .done_o           (done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] gen_word(input int seed, input int k);
    logic [31:0] a;
    a = 32'(seed + 1) * 32'h9E37_79B9;
    return a ^ (32'h0123_4567 + 32'(k) * 32'h1111_1111);
  endfunction

  task automatic build_exp(input bit mode, input logic [63:0] count, input int nw, input int tn);
    logic [31:0] tail, m, lo, hi;
    logic [63:0] pos, len_b, bits;
    exp_n = 0;
    for (int k = 0; k < nw; k++) begin
      exp_w[exp_n] = req_data[32*k +: 32]; exp_tag[exp_n] = "R2"; exp_n++;
    end
    tail = req_data[32*nw +: 32];
    m = '0;
    for (int j = 0; j < 4; j++) begin
      if (j < tn)       m[8*j +: 8] = tail[8*j +: 8];
      else if (j == tn) m[8*j +: 8] = 8'h80;
    end
    exp_w[exp_n] = m; exp_tag[exp_n] = "R3"; exp_n++;
    pos = count + 64'(4 * (nw + 1));
    while (pos[5:0] != 6'd56) begin
      exp_w[exp_n] = '0; exp_tag[exp_n] = mode ? "R5" : "R4"; exp_n++;
      pos = pos + 64'd4;
    end
    len_b = count + 64'(4 * nw + tn);
    bits  = len_b << 3;
    if (mode) begin
      for (int j = 0; j < 4; j++) begin
        lo[8*j +: 8] = bits[63 - 8*j -: 8];
        hi[8*j +: 8] = bits[31 - 8*j -: 8];
      end
      exp_tag[exp_n] = "R7"; exp_tag[exp_n+1] = "R7";
    end else begin
      lo = bits[31:0]; hi = bits[63:32];
      exp_tag[exp_n] = "R6"; exp_tag[exp_n+1] = "R6";
    end
    exp_w[exp_n] = lo; exp_w[exp_n+1] = hi;
    exp_n += 2;
  endtask

  task automatic run_case(input string name, input bit mode, input logic [63:0] count,
                          input int nw, input int tn, input int seed,
                          input bit stall, input bit poke);
    int got, cyc;
    bit pend, fin;
    for (int k = 0; k < BW; k++) req_data[32*k +: 32] = gen_word(seed, k);
    build_exp(mode, count, nw, tn);
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", {name, " idle ready"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_mode = mode; req_count = count;
    req_words = 4'(nw); req_tail = 2'(tn); out_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; cyc = 0; pend = 0; fin = 0;
    while (!fin && cyc < 500) begin
      cyc++;
      if (poke && cyc == 3) begin
        req_valid = 1'b1; req_mode = ~mode; req_words = 4'd2; req_tail = 2'd1;
        req_count = 64'h40; req_data = ~req_data;
      end
      if (poke && cyc == 6) req_valid = 1'b0;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #0.5;
      if (pend) begin
        chk(done === 1'b1, "R10", {name, " done pulse"}, 64'(done), 64'd1);
        fin = 1;
      end else begin
        if (poke && cyc == 4)
          chk(req_ready === 1'b0, "R11", {name, " busy ready"}, 64'(req_ready), 64'd0);
        if (out_valid && out_ready) begin
          if (got < exp_n)
            chk(out_data === exp_w[got], exp_tag[got],
                $sformatf("%s word %0d", name, got), 64'(out_data), 64'(exp_w[got]));
          chk(out_last === (got == exp_n - 1), "R9",
              $sformatf("%s last flag word %0d", name, got), 64'(out_last), 64'(got == exp_n - 1));
          got++;
          if (out_last) pend = 1;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0; req_valid = 1'b0;
    chk(got == exp_n, mode ? "R5" : "R4", {name, " word count"}, 64'(got), 64'(exp_n));
    chk(got % 16 == 0, "R8", {name, " block multiple"}, 64'(got % 16), 64'd0);
    #0.5;
    chk(done === 1'b0, "R10", {name, " done single"}, 64'(done), 64'd0);
  endtask

  task automatic test_reset();
    #1;
    chk(out_valid === 1'b0, "R1", "valid in reset", 64'(out_valid), 64'd0);
    chk(req_ready === 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    chk(done === 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5;
    chk(out_valid === 1'b0, "R1", "valid after reset", 64'(out_valid), 64'd0);
    chk(req_ready === 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
  endtask

  task automatic test_empty();
    run_case("md5 empty", 1'b0, 64'd0, 0, 0, 1, 1'b0, 1'b0);
    run_case("sha1 empty", 1'b1, 64'd0, 0, 0, 2, 1'b0, 1'b0);
  endtask

  task automatic test_md5_wrap();
    run_case("md5 idx56", 1'b0, 64'd64, 13, 2, 3, 1'b0, 1'b0);
    run_case("md5 idx0", 1'b0, 64'd320, 15, 3, 4, 1'b0, 1'b0);
  endtask

  task automatic test_sha1_wrap();
    run_case("sha1 idx55", 1'b1, 64'd128, 13, 3, 5, 1'b0, 1'b0);
    run_case("sha1 idx56", 1'b1, 64'd192, 14, 0, 6, 1'b0, 1'b0);
  endtask

  task automatic test_stall_large();
    run_case("md5 large stall", 1'b0, 64'h0000_0012_3456_7800, 7, 1, 7, 1'b1, 1'b0);
    run_case("sha1 large stall busy", 1'b1, 64'h0ABC_DEF0_1234_5640, 5, 2, 8, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_empty();
    test_md5_wrap();
    test_sha1_wrap();
    test_stall_large();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule